// File: doc/BRIEF.md
# Packet DMA Channel Register Block

This block is the host-visible register front end for a multi-channel, packet-driven disk DMA engine. A host issues single-cycle register writes and reads on a flat byte-addressed window. The block splits that window into per-channel blocks. Each block holds a control word, a sticky event status byte, a packet count, a next-packet pointer and two FIFO threshold words.

Toward each channel's engine core, the block drives a one-cycle start pulse, a one-cycle logic-reset pulse, the interrupt mask and the transfer-mode bits. It also drives the configuration values. Completion and error events come back from the core as single-cycle pulses. They are latched into the status byte, which clears itself when the host reads it. A per-channel interrupt output is raised while any status bit is pending and the mask is clear.

Read data is combinational from the address while the read strobe is high. The read-clear takes effect at the clock edge that ends the read cycle.

Top module: `dchan_regs`

## Requirements
- R1: With defaults, channel k occupies bytes 0x80+0x20*k to 0x9F+0x20*k.
  - Register offsets within a channel are: control 0x00, status 0x02, packet count 0x04, packet pointer 0x0C, input threshold 0x14, output threshold 0x16.
  - Any other address reads 0, and writes to it change nothing.
- R2: After reset, each channel reads as follows: control 0x0103 (mask set, mode 3), status 0, count 1, pointer 0, both thresholds 0x0100. All irq, go and reset outputs are low.
- R3: A control write with bit 7 set and bit 5 clear gives exactly one high cycle on go_pulse, in the cycle after the write. Bit 7 always reads back 0.
- R4: A control write with bit 5 set has these effects:
  - eng_reset is high for the one cycle after the write, and no go pulse is produced even if bit 7 is set.
  - Status is cleared at that write's edge, which drops any event arriving in that cycle.
  - Count, pointer and thresholds keep their values, and bit 5 reads back 0.
- R5: A control write stores bit 8 (interrupt mask, 1 = masked) and bits 1:0 (mode), which appear on irq_mask and pio_mode. Other bits read 0. A control write without bit 7 produces no go pulse.
- R6: An event pulse sets its sticky status bit at the next edge: bus error at bit 0, unexpected interrupt at bit 4, packet sequence at bit 6. Other status bits read 0.
- R7: A status read returns the pending bits and clears them at the end of the read cycle. An event arriving in the read cycle is kept for the next read.
- R8: irq[k] is high exactly when channel k's status is non-zero and its mask bit is 0.
- R9: The channels are independent. Writes, events and reads on one channel leave the other channel's registers and outputs unchanged.
- R10: The count (16 bits), pointer (32 bits) and both thresholds (16 bits each) store the written value and read it back zero-extended.
- R11: Host writes to the status offset have no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| ev_bus_err | input | NUM_CH | Core event: host bus error |
| ev_unexp_irq | input | NUM_CH | Core event: unexpected interrupt |
| ev_pkt_seq | input | NUM_CH | Core event: packet sequence |
| go_pulse | output | NUM_CH | One-cycle packet start |
| eng_reset | output | NUM_CH | One-cycle engine logic reset |
| irq_mask | output | NUM_CH | Interrupt mask bit |
| pio_mode | output | 2*NUM_CH | Transfer mode bits per channel |
| pkt_count | output | 16*NUM_CH | Packet count per channel |
| pkt_ptr | output | 32*NUM_CH | Next-packet pointer per channel |
| fifo_in_thr | output | 16*NUM_CH | Input FIFO threshold per channel |
| fifo_out_thr | output | 16*NUM_CH | Output FIFO threshold per channel |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
Two pairs of functions can fall on the same edge.

The first pair is the status read-clear and a new core event. The bench raises an event pulse in the very cycle it reads status. It expects the old bits in the read data and the new bit alone on the following read.

The second pair is an engine-reset write and an event. The bench drives both together and expects status to read zero afterwards. It also drives an engine-reset write with the go bit set, and judges that only the reset pulse appears.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  localparam int OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 5'h02;
  localparam logic [OFS_W-1:0] OFS_CNT  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_PTR  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_FIN  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_FOUT = 5'h16;

  localparam int CB_MASK = 8;
  localparam int CB_GO   = 7;
  localparam int CB_RST  = 5;

  localparam int SB_BUS   = 0;
  localparam int SB_UNEXP = 4;
  localparam int SB_SEQ   = 6;

  localparam logic [1:0]  PIO_RST = 2'd3;
  localparam logic [15:0] CNT_RST = 16'd1;
  localparam logic [15:0] THR_RST = 16'h0100;

  typedef struct packed {
    logic seq;
    logic unexp;
    logic bus;
  } evt_t;

  function automatic logic [7:0] stat_byte(evt_t s);
    logic [7:0] b;
    b = '0;
    b[SB_BUS]   = s.bus;
    b[SB_UNEXP] = s.unexp;
    b[SB_SEQ]   = s.seq;
    return b;
  endfunction

  // engine clear wins; a read keeps only what arrives in the read cycle
  function automatic evt_t stat_next(evt_t cur, evt_t ev, logic rd_clr, logic eng_clr);
    if (eng_clr) return '0;
    if (rd_clr) return ev;
    return evt_t'(cur | ev);
  endfunction

  function automatic logic [15:0] ctrl_view(logic mask, logic [1:0] pio);
    logic [15:0] v;
    v = '0;
    v[CB_MASK] = mask;
    v[1:0]     = pio;
    return v;
  endfunction

  function automatic logic [31:0] reg_view(logic [OFS_W-1:0] ofs, logic [15:0] ctrl,
                                           logic [7:0] stat, logic [15:0] cnt,
                                           logic [31:0] ptr, logic [15:0] fin,
                                           logic [15:0] fout);
    logic [31:0] v;
    case (ofs)
      OFS_CTRL: v = {16'd0, ctrl};
      OFS_STAT: v = {24'd0, stat};
      OFS_CNT:  v = {16'd0, cnt};
      OFS_PTR:  v = ptr;
      OFS_FIN:  v = {16'd0, fin};
      OFS_FOUT: v = {16'd0, fout};
      default:  v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dchan_decode.sv
module dchan_decode
  import dchan_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 'h80
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [NUM_CH-1:0] wr_sel,
  output logic [NUM_CH-1:0] rd_sel,
  output logic [OFS_W-1:0]  ofs
);
  localparam int BLK_W    = ADDR_W - OFS_W;
  localparam int BASE_BLK = CH_BASE >> OFS_W;

  assign ofs = addr[OFS_W-1:0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit       = (addr[ADDR_W-1:OFS_W] == BLK_W'(BASE_BLK + k));
    assign wr_sel[k] = wr_en && hit;
    assign rd_sel[k] = rd_en && hit;
  end
endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        wr_mask,
  input  logic        wr_go,
  input  logic        wr_rst,
  input  logic [1:0]  wr_pio,
  output logic        go_pulse,
  output logic        eng_reset,
  output logic        eng_clr,
  output logic        irq_mask,
  output logic [1:0]  pio,
  output logic [15:0] view
);
  logic go_req;

  assign eng_clr = wr && wr_rst;
  assign go_req  = wr && wr_go && !wr_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_pulse  <= 1'b0;
      eng_reset <= 1'b0;
      irq_mask  <= 1'b1;
      pio       <= PIO_RST;
    end else begin
      go_pulse  <= go_req;
      eng_reset <= eng_clr;
      if (wr) begin
        irq_mask <= wr_mask;
        pio      <= wr_pio;
      end
    end
  end

  assign view = ctrl_view(irq_mask, pio);
endmodule

// File: rtl/dchan_status.sv
module dchan_status
  import dchan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_t       ev,
  input  logic       rd_clr,
  input  logic       eng_clr,
  output logic [7:0] stat
);
  evt_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= stat_next(q, ev, rd_clr, eng_clr);
  end

  assign stat = stat_byte(q);
endmodule

// File: rtl/dchan_cfg.sv
module dchan_cfg
  import dchan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [31:0]      wdata,
  output logic [15:0]      cnt,
  output logic [31:0]      ptr,
  output logic [15:0]      fin,
  output logic [15:0]      fout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CNT_RST;
      ptr  <= '0;
      fin  <= THR_RST;
      fout <= THR_RST;
    end else if (wr) begin
      if (ofs == OFS_CNT)  cnt  <= wdata[15:0];
      if (ofs == OFS_PTR)  ptr  <= wdata;
      if (ofs == OFS_FIN)  fin  <= wdata[15:0];
      if (ofs == OFS_FOUT) fout <= wdata[15:0];
    end
  end
endmodule

// File: rtl/dchan_regs.sv
module dchan_regs
  import dchan_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_CH-1:0]    ev_bus_err,
  input  logic [NUM_CH-1:0]    ev_unexp_irq,
  input  logic [NUM_CH-1:0]    ev_pkt_seq,
  output logic [NUM_CH-1:0]    go_pulse,
  output logic [NUM_CH-1:0]    eng_reset,
  output logic [NUM_CH-1:0]    irq_mask,
  output logic [2*NUM_CH-1:0]  pio_mode,
  output logic [16*NUM_CH-1:0] pkt_count,
  output logic [32*NUM_CH-1:0] pkt_ptr,
  output logic [16*NUM_CH-1:0] fifo_in_thr,
  output logic [16*NUM_CH-1:0] fifo_out_thr,
  output logic [NUM_CH-1:0]    irq
);
  logic [NUM_CH-1:0]   wr_sel;
  logic [NUM_CH-1:0]   rd_sel;
  logic [OFS_W-1:0]    ofs;
  logic [8*NUM_CH-1:0] stat_flat;
  logic [31:0]         view [NUM_CH];

  dchan_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CH_BASE(CH_BASE)
  ) u_dec (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wr_sel(wr_sel),
    .rd_sel(rd_sel),
    .ofs   (ofs)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic        ctrl_wr;
    logic        stat_rd;
    logic        eng_clr;
    logic [15:0] cv;
    logic [7:0]  sv;
    evt_t        ev_k;

    assign ctrl_wr = wr_sel[k] && (ofs == OFS_CTRL);
    assign stat_rd = rd_sel[k] && (ofs == OFS_STAT);
    assign ev_k    = '{seq: ev_pkt_seq[k], unexp: ev_unexp_irq[k], bus: ev_bus_err[k]};

    dchan_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wr_mask  (wdata[CB_MASK]),
      .wr_go    (wdata[CB_GO]),
      .wr_rst   (wdata[CB_RST]),
      .wr_pio   (wdata[1:0]),
      .go_pulse (go_pulse[k]),
      .eng_reset(eng_reset[k]),
      .eng_clr  (eng_clr),
      .irq_mask (irq_mask[k]),
      .pio      (pio_mode[2*k +: 2]),
      .view     (cv)
    );

    dchan_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_k),
      .rd_clr (stat_rd),
      .eng_clr(eng_clr),
      .stat   (sv)
    );

    dchan_cfg u_cfg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_sel[k]),
      .ofs  (ofs),
      .wdata(wdata),
      .cnt  (pkt_count[16*k +: 16]),
      .ptr  (pkt_ptr[32*k +: 32]),
      .fin  (fifo_in_thr[16*k +: 16]),
      .fout (fifo_out_thr[16*k +: 16])
    );

    assign stat_flat[8*k +: 8] = sv;
    assign irq[k]  = (sv != 8'd0) && !irq_mask[k];
    assign view[k] = reg_view(ofs, cv, sv, pkt_count[16*k +: 16], pkt_ptr[32*k +: 32],
                              fifo_in_thr[16*k +: 16], fifo_out_thr[16*k +: 16]);
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_sel[k]) rdata = rdata | view[k];
    end
  end
endmodule

// File: rtl/dchan_regs_chk.sv
module dchan_regs_chk #(
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              w_go,
  input logic              w_rst,
  input logic              ev0_any,
  input logic              go0,
  input logic              rst0,
  input logic              mask0,
  input logic              irq0,
  input logic [7:0]        stat0,
  input logic [31:0]       ptr0
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CH_BASE + 2);

  // R3
  go_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go0 |-> $past(wr_en && (addr == A_CTRL) && w_go && !w_rst));

  // R4
  go_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go0 && rst0));

  // R4
  rst_clears_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst0 |-> (stat0 == 8'd0));

  // R4
  rst_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst0 |-> $stable(ptr0));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_STAT) && !ev0_any) |=> (stat0 == 8'd0));

  // R8
  mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask0 |-> !irq0);

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq0) |-> ($past(ev0_any) || $fell(mask0)));
endmodule

bind dchan_regs dchan_regs_chk #(
  .ADDR_W (ADDR_W),
  .CH_BASE(CH_BASE)
) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .w_go   (wdata[dchan_pkg::CB_GO]),
  .w_rst  (wdata[dchan_pkg::CB_RST]),
  .ev0_any(ev_bus_err[0] | ev_unexp_irq[0] | ev_pkt_seq[0]),
  .go0    (go_pulse[0]),
  .rst0   (eng_reset[0]),
  .mask0  (irq_mask[0]),
  .irq0   (irq[0]),
  .stat0  (stat_flat[7:0]),
  .ptr0   (pkt_ptr[31:0])
);

// File: tb/test_dchan_regs.sv
module test_dchan_regs;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 8;
  localparam int CH_BASE = 'h80;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_en = 1'b0;
  logic                 rd_en = 1'b0;
  logic [ADDR_W-1:0]    addr = '0;
  logic [31:0]          wdata = '0;
  logic [31:0]          rdata;
  logic [NUM_CH-1:0]    ev_bus_err = '0;
  logic [NUM_CH-1:0]    ev_unexp_irq = '0;
  logic [NUM_CH-1:0]    ev_pkt_seq = '0;
  logic [NUM_CH-1:0]    go_pulse;
  logic [NUM_CH-1:0]    eng_reset;
  logic [NUM_CH-1:0]    irq_mask;
  logic [2*NUM_CH-1:0]  pio_mode;
  logic [16*NUM_CH-1:0] pkt_count;
  logic [32*NUM_CH-1:0] pkt_ptr;
  logic [16*NUM_CH-1:0] fifo_in_thr;
  logic [16*NUM_CH-1:0] fifo_out_thr;
  logic [NUM_CH-1:0]    irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dchan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE)) i_dchan_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_bus_err(ev_bus_err),
    .ev_unexp_irq(ev_unexp_irq), .ev_pkt_seq(ev_pkt_seq), .go_pulse(go_pulse),
    .eng_reset(eng_reset), .irq_mask(irq_mask), .pio_mode(pio_mode),
    .pkt_count(pkt_count), .pkt_ptr(pkt_ptr), .fifo_in_thr(fifo_in_thr),
    .fifo_out_thr(fifo_out_thr), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] ra(int ch, int ofs);
    return ADDR_W'(CH_BASE + 32*ch + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // bits: [0] bus error, [1] unexpected irq, [2] packet sequence
  task automatic pulse_ev(int ch, logic [2:0] e);
    @(negedge clk);
    ev_bus_err[ch] = e[0]; ev_unexp_irq[ch] = e[1]; ev_pkt_seq[ch] = e[2];
    @(negedge clk);
    ev_bus_err = '0; ev_unexp_irq = '0; ev_pkt_seq = '0;
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rd(ra(ch, 'h00), d); chk("R2 ctrl", d, 32'h0103);
      rd(ra(ch, 'h02), d); chk("R2 status", d, 0);
      rd(ra(ch, 'h04), d); chk("R2 count", d, 1);
      rd(ra(ch, 'h0C), d); chk("R2 ptr", d, 0);
      rd(ra(ch, 'h14), d); chk("R2 fin", d, 32'h100);
      rd(ra(ch, 'h16), d); chk("R2 fout", d, 32'h100);
    end
    chk("R2 irq", irq, 0);
    chk("R2 go", go_pulse, 0);
    chk("R2 eng_reset", eng_reset, 0);
    chk("R2 pio", pio_mode, 4'hF);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(ra(0, 'h04), 32'hABCD_0007);
    wr(ra(0, 'h0C), 32'hDEAD_BEE8);
    wr(ra(0, 'h14), 32'h0000_0040);
    wr(ra(0, 'h16), 32'h1234_0080);
    rd(ra(0, 'h04), d); chk("R10 count", d, 32'h0007);
    rd(ra(0, 'h0C), d); chk("R10 ptr", d, 32'hDEAD_BEE8);
    rd(ra(0, 'h14), d); chk("R10 fin", d, 32'h0040);
    rd(ra(0, 'h16), d); chk("R10 fout", d, 32'h0080);
    chk("R10 ptr port", pkt_ptr[31:0], 32'hDEAD_BEE8);
    wr(ra(0, 'h08), 32'hFFFF_FFFF);
    rd(ra(0, 'h08), d); chk("R1 unmapped read", d, 0);
    rd(ra(0, 'h0C), d); chk("R1 unmapped write ignored", d, 32'hDEAD_BEE8);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 outside window", d, 0);
    rd(ra(1, 'h0C), d); chk("R9 ch1 ptr untouched", d, 0);
    rd(ra(1, 'h04), d); chk("R9 ch1 count untouched", d, 1);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(ra(0, 'h00), 32'h0000_0183);
    chk("R3 go pulse high", go_pulse, 2'b01);
    chk("R3 no reset pulse", eng_reset, 0);
    @(negedge clk);
    chk("R3 go pulse one cycle", go_pulse, 0);
    rd(ra(0, 'h00), d); chk("R3 go reads 0", d, 32'h0103);
    wr(ra(0, 'h00), 32'h0000_7E5E);
    chk("R5 no go without bit7", go_pulse, 0);
    chk("R5 mask cleared", irq_mask, 2'b10);
    chk("R5 pio", pio_mode, 4'b1110);
    rd(ra(0, 'h00), d); chk("R5 other bits 0", d, 32'h0002);
    wr(ra(0, 'h00), 32'h0000_0003);
    chk("R5 plain write no go", go_pulse, 0);
    chk("R9 ch1 mask kept", irq_mask[1], 1);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_ev(0, 3'b001);
    chk("R8 irq raised", irq, 2'b01);
    rd(ra(0, 'h02), d); chk("R6 bus error bit0", d, 32'h01);
    chk("R7 irq gone after read", irq, 0);
    rd(ra(0, 'h02), d); chk("R7 cleared", d, 0);
    pulse_ev(0, 3'b110);
    rd(ra(1, 'h02), d); chk("R9 ch1 status clean", d, 0);
    chk("R9 ch1 irq low", irq[1], 0);
    rd(ra(0, 'h02), d); chk("R6 unexp+seq bits 4,6", d, 32'h50);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(ra(0, 'h00), 32'h0000_0103);
    pulse_ev(0, 3'b100);
    chk("R8 masked irq low", irq[0], 0);
    wr(ra(0, 'h00), 32'h0000_0003);
    chk("R8 unmask irq high", irq[0], 1);
    rd(ra(0, 'h02), d); chk("R8 pending kept while masked", d, 32'h40);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse_ev(0, 3'b001);
    @(negedge clk);
    rd_en = 1'b1; addr = ra(0, 'h02); ev_pkt_seq[0] = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; ev_pkt_seq = '0;
    chk("R7 read returns old bits", d, 32'h01);
    chk("R7 same-cycle event irq", irq[0], 1);
    rd(ra(0, 'h02), d); chk("R7 same-cycle event kept", d, 32'h40);
  endtask

  task automatic t_eng_reset();
    logic [31:0] d;
    pulse_ev(0, 3'b011);
    wr(ra(0, 'h00), 32'h0000_0023);
    chk("R4 reset pulse", eng_reset, 2'b01);
    chk("R4 no go", go_pulse, 0);
    @(negedge clk);
    chk("R4 reset one cycle", eng_reset, 0);
    rd(ra(0, 'h02), d); chk("R4 status cleared", d, 0);
    rd(ra(0, 'h0C), d); chk("R4 ptr kept", d, 32'hDEAD_BEE8);
    rd(ra(0, 'h04), d); chk("R4 count kept", d, 32'h0007);
    rd(ra(0, 'h14), d); chk("R4 fin kept", d, 32'h0040);
    rd(ra(0, 'h00), d); chk("R4 bit5 reads 0", d, 32'h0003);
    wr(ra(0, 'h00), 32'h0000_00A3);
    chk("R4 go+rst gives reset", eng_reset, 2'b01);
    chk("R4 go+rst suppresses go", go_pulse, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = ra(0, 'h00); wdata = 32'h0000_0023; ev_bus_err[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_bus_err = '0;
    rd(ra(0, 'h02), d); chk("R4 reset drops same-cycle event", d, 0);
  endtask

  task automatic t_status_write();
    logic [31:0] d;
    wr(ra(0, 'h02), 32'h0000_00FF);
    rd(ra(0, 'h02), d); chk("R11 write does not set", d, 0);
    pulse_ev(0, 3'b001);
    wr(ra(0, 'h02), 32'h0);
    rd(ra(0, 'h02), d); chk("R11 write does not clear", d, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_values();
    t_map();
    t_ctrl();
    t_events();
    t_mask();
    t_race();
    t_eng_reset();
    t_status_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule